// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block is the control and status side of a NOR-style flash array. It does not store any array data. The command decoder upstream hands it one decoded request per cycle. A request is a program, erase, suspend, resume, clear-status or sequence-error code, together with a block index. The array model beside it supplies a verify pass/fail result after each pulse. Board logic supplies a write-protect level and a programming-supply-good level.

Each accepted program or erase runs as a loop of pulse phases and verify phases. A program gets a single attempt. An erase is retried until a parameterised pulse limit is reached. The outcome is reported in an 8-bit status byte and a ready flag, which software polls. A running operation can be suspended; while it is suspended the block reads as ready. When write-protect is low, the two highest-numbered blocks refuse any modification.

Top module: `flash_wsm_status`

## Requirements
- R1: After reset the status byte is 0x80 and ready is 1.
- R2: Status bit 0 always reads 0. Ready always equals status bit 7.
- R3: A program (req_op 1) or erase (req_op 2) accepted while idle and not suspended makes ready 0 from the next cycle on.
- R4: With wp_n low, a program or erase aimed at block NUM_BLOCKS-2 or NUM_BLOCKS-1 is refused. It sets status bit 1 and ready stays 1. With wp_n high, the same request is accepted.
- R5: vpp_ok is sampled when a program or erase is issued and again at each verify phase. A low sample ends the operation with status bit 3 set and ready 1.
- R6: A program whose verify fails ends with status bit 4 set and ready 1. A program takes two busy cycles: one pulse and one verify.
- R7: An erase alternates a pulse cycle and a verify cycle. It ends on the first passing verify. After PULSE_LIMIT failing verifies it ends with status bit 5 set, after 2*PULSE_LIMIT busy cycles.
- R8: A suspend (req_op 3) during a running operation makes ready 1 on the next cycle. It sets bit 6 for an erase or bit 2 for a program. That bit holds until a resume (req_op 4), after which the block is busy again.
- R9: A resume while nothing is suspended leaves the status byte unchanged.
- R10: Clear-status (req_op 5) clears bits 5, 4, 3 and 1. It also works while suspended, and it leaves bits 6 and 2 untouched.
- R11: A sequence-error report (req_op 6) while idle sets bits 7, 5 and 4 together.
- R12: A verify that passes with the supply good ends the operation with ready 1. It sets no new error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code: 1 program, 2 erase, 3 suspend, 4 resume, 5 clear status, 6 sequence error |
| req_blk | input | BLK_W | Target block index |
| wp_n | input | 1 | Write protect, low locks the top two blocks |
| vpp_ok | input | 1 | Programming supply good |
| verify_pass | input | 1 | Verify result from the array model |
| ready | output | 1 | State machine ready (idle or suspended) |
| status | output | 8 | Status byte |

## Verification
The bound checker watches, on every cycle, the relations that are local in time. Bit 0 stays at zero. A suspend bit is never shown while busy. Suspend bits hold until a resume. A locked, low-supply, sequence-error or clear request gives the right status one cycle later. An accept drops ready, and a stray resume leaves the status alone. The bench scenarios cover the multi-cycle behaviour: how long a program or erase takes, the pulse count that ends a failing erase, and a suspended operation picking up its pulse loop again after resume. A long random run, compared cycle by cycle with an independent model, covers the interleavings.

// File: rtl/flash_wsm_pkg.sv
package flash_wsm_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4,
        OP_CLEAR  = 3'd5,
        OP_SEQERR = 3'd6
    } wsm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_CHECK = 2'd2,
        ST_SUSP  = 2'd3
    } wsm_state_e;

    typedef struct packed {
        wsm_state_e st;
        logic       is_erase;
        logic       f_erase;
        logic       f_prog;
        logic       f_supply;
        logic       f_lock;
    } wsm_regs_t;

endpackage

// File: rtl/flash_lock_decode.sv
module flash_lock_decode #(
    parameter int unsigned NUM_BLOCKS = 23,
    parameter int unsigned LOCK_COUNT = 2,
    localparam int unsigned BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic [BLK_W-1:0] blk,
    input  logic             wp_n,
    output logic             locked
);

    logic [LOCK_COUNT-1:0] hit;

    for (genvar g = 0; g < LOCK_COUNT; g++) begin : g_top
        localparam int unsigned IDX = NUM_BLOCKS - 1 - g;
        assign hit[g] = (blk == BLK_W'(IDX));
    end

    assign locked = !wp_n && (|hit);

endmodule

// File: rtl/flash_pulse_counter.sv
module flash_pulse_counter #(
    parameter int unsigned PULSE_LIMIT = 4,
    localparam int unsigned CNT_W = $clog2(PULSE_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q < CNT_W'(PULSE_LIMIT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q >= CNT_W'(PULSE_LIMIT));

endmodule

// File: rtl/flash_status_pack.sv
module flash_status_pack (
    input  logic       rdy,
    input  logic       susp_erase,
    input  logic       susp_prog,
    input  logic       f_erase,
    input  logic       f_prog,
    input  logic       f_supply,
    input  logic       f_lock,
    output logic [7:0] status
);

    always_comb begin
        status    = '0;
        status[7] = rdy;
        status[6] = susp_erase;
        status[5] = f_erase;
        status[4] = f_prog;
        status[3] = f_supply;
        status[2] = susp_prog;
        status[1] = f_lock;
        status[0] = 1'b0;
    end

endmodule

// File: rtl/flash_wsm_status.sv
module flash_wsm_status
    import flash_wsm_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS  = 23,
    parameter int unsigned PULSE_LIMIT = 4,
    localparam int unsigned BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             wp_n,
    input  logic             vpp_ok,
    input  logic             verify_pass,
    output logic             ready,
    output logic [7:0]       status
);

    wsm_regs_t r_d, r_q;
    wsm_op_e   op;
    logic      blk_locked;
    logic      cnt_clr, cnt_inc, cnt_at_limit;
    logic      want_susp, want_resume, want_clear;

    flash_lock_decode #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .LOCK_COUNT(2)
    ) i_lock (
        .blk    (req_blk),
        .wp_n   (wp_n),
        .locked (blk_locked)
    );

    flash_pulse_counter #(
        .PULSE_LIMIT(PULSE_LIMIT)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .at_limit (cnt_at_limit)
    );

    assign op          = wsm_op_e'(req_op);
    assign want_susp   = req_valid && (op == OP_SUSP);
    assign want_resume = req_valid && (op == OP_RESUME);
    assign want_clear  = req_valid && (op == OP_CLEAR);

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    case (op)
                        OP_PROG, OP_ERASE: begin
                            if (blk_locked) begin
                                r_d.f_lock = 1'b1;
                            end else if (!vpp_ok) begin
                                r_d.f_supply = 1'b1;
                            end else begin
                                r_d.st       = ST_PULSE;
                                r_d.is_erase = (op == OP_ERASE);
                                cnt_clr      = 1'b1;
                            end
                        end
                        OP_CLEAR: begin
                            r_d.f_erase  = 1'b0;
                            r_d.f_prog   = 1'b0;
                            r_d.f_supply = 1'b0;
                            r_d.f_lock   = 1'b0;
                        end
                        OP_SEQERR: begin
                            r_d.f_erase = 1'b1;
                            r_d.f_prog  = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PULSE: begin
                if (want_susp) begin
                    r_d.st = ST_SUSP;
                end else begin
                    cnt_inc = 1'b1;
                    r_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (want_susp) begin
                    r_d.st = ST_SUSP;
                end else if (!vpp_ok) begin
                    r_d.f_supply = 1'b1;
                    r_d.st       = ST_IDLE;
                end else if (verify_pass) begin
                    r_d.st = ST_IDLE;
                end else if (!r_q.is_erase) begin
                    r_d.f_prog = 1'b1;
                    r_d.st     = ST_IDLE;
                end else if (cnt_at_limit) begin
                    r_d.f_erase = 1'b1;
                    r_d.st      = ST_IDLE;
                end else begin
                    r_d.st = ST_PULSE;
                end
            end
            ST_SUSP: begin
                if (want_resume) begin
                    r_d.st = ST_PULSE;
                end else if (want_clear) begin
                    r_d.f_erase  = 1'b0;
                    r_d.f_prog   = 1'b0;
                    r_d.f_supply = 1'b0;
                    r_d.f_lock   = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready = (r_q.st == ST_IDLE) || (r_q.st == ST_SUSP);

    flash_status_pack i_pack (
        .rdy        ((r_q.st == ST_IDLE) || (r_q.st == ST_SUSP)),
        .susp_erase ((r_q.st == ST_SUSP) && r_q.is_erase),
        .susp_prog  ((r_q.st == ST_SUSP) && !r_q.is_erase),
        .f_erase    (r_q.f_erase),
        .f_prog     (r_q.f_prog),
        .f_supply   (r_q.f_supply),
        .f_lock     (r_q.f_lock),
        .status     (status)
    );

endmodule

// File: rtl/flash_wsm_status_chk.sv
module flash_wsm_status_chk #(
    parameter int unsigned NUM_BLOCKS = 23,
    localparam int unsigned BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic [BLK_W-1:0] req_blk,
    input logic             wp_n,
    input logic             vpp_ok,
    input logic             ready,
    input logic [7:0]       status
);

    logic idle_now, modify_req, top_blk;

    assign idle_now   = ready && !status[6] && !status[2];
    assign modify_req = req_valid && ((req_op == 3'd1) || (req_op == 3'd2));
    assign top_blk    = (int'(req_blk) >= int'(NUM_BLOCKS) - 2) && (int'(req_blk) < int'(NUM_BLOCKS));

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == 1'b0);                                                          // R2

    AST_SUSP_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] || status[2]) |-> ready);                                         // R8

    AST_SUSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[6] || status[2]) && !(req_valid && req_op == 3'd4)) |=> $stable(status[6]) && $stable(status[2])); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && modify_req && !(top_blk && !wp_n) && vpp_ok) |=> !ready);       // R3

    AST_LOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && modify_req && top_blk && !wp_n) |=> (status[1] && ready));      // R4

    AST_SUPPLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && modify_req && !(top_blk && !wp_n) && !vpp_ok) |=> (status[3] && ready)); // R5

    AST_RESUME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && req_valid && req_op == 3'd4) |=> $stable(status));              // R9

    AST_CLEAR_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_op == 3'd5) |=> (status[5:3] == 3'b000 && !status[1])); // R10

    AST_SEQERR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && req_valid && req_op == 3'd6) |=> (status[7] && status[5] && status[4])); // R11

endmodule

bind flash_wsm_status flash_wsm_status_chk #(
    .NUM_BLOCKS(NUM_BLOCKS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_blk   (req_blk),
    .wp_n      (wp_n),
    .vpp_ok    (vpp_ok),
    .ready     (ready),
    .status    (status)
);

// File: tb/test_flash_wsm_status.sv
module test_flash_wsm_status;

    localparam int NB    = 23;
    localparam int PL    = 4;
    localparam int BLK_W = $clog2(NB);

    localparam logic [2:0] C_NONE = 3'd0, C_PROG = 3'd1, C_ERASE = 3'd2, C_SUSP = 3'd3,
                           C_RES = 3'd4, C_CLR = 3'd5, C_SEQ = 3'd6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_op = '0;
    logic [BLK_W-1:0] req_blk = '0;
    logic             wp_n = 1'b1;
    logic             vpp_ok = 1'b1;
    logic             verify_pass = 1'b1;
    logic             ready;
    logic [7:0]       status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_wsm_status #(.NUM_BLOCKS(NB), .PULSE_LIMIT(PL)) i_flash_wsm_status (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .wp_n(wp_n), .vpp_ok(vpp_ok), .verify_pass(verify_pass),
        .ready(ready), .status(status)
    );

    // reference model: 0 idle, 1 pulse, 2 verify, 3 suspended
    int m_st = 0;
    bit m_er = 0;
    int m_cnt = 0;
    bit m5 = 0, m4 = 0, m3 = 0, m1 = 0;

    task automatic model_step(input logic [2:0] op, input int blk, input bit wp, input bit vpp, input bit vp);
        case (m_st)
            0: begin
                if (op == C_PROG || op == C_ERASE) begin
                    if (!wp && blk >= NB - 2) m1 = 1;
                    else if (!vpp) m3 = 1;
                    else begin m_st = 1; m_er = (op == C_ERASE); m_cnt = 0; end
                end else if (op == C_CLR) begin
                    m5 = 0; m4 = 0; m3 = 0; m1 = 0;
                end else if (op == C_SEQ) begin
                    m5 = 1; m4 = 1;
                end
            end
            1: begin
                if (op == C_SUSP) m_st = 3;
                else begin m_cnt++; m_st = 2; end
            end
            2: begin
                if (op == C_SUSP) m_st = 3;
                else if (!vpp) begin m3 = 1; m_st = 0; end
                else if (vp) m_st = 0;
                else if (!m_er) begin m4 = 1; m_st = 0; end
                else if (m_cnt >= PL) begin m5 = 1; m_st = 0; end
                else m_st = 1;
            end
            default: begin
                if (op == C_RES) m_st = 1;
                else if (op == C_CLR) begin m5 = 0; m4 = 0; m3 = 0; m1 = 0; end
            end
        endcase
    endtask

    function automatic logic [7:0] model_status();
        return {(m_st == 0 || m_st == 3), (m_st == 3 && m_er), m5, m4, m3,
                (m_st == 3 && !m_er), m1, 1'b0};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] op, input int blk, input bit wp, input bit vpp, input bit vp);
        req_valid   = (op != C_NONE);
        req_op      = op;
        req_blk     = BLK_W'(blk);
        wp_n        = wp;
        vpp_ok      = vpp;
        verify_pass = vp;
        model_step(op, blk, wp, vpp, vp);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        repeat (2) @(negedge clk);
        check8("R1 reset status", status, 8'h80);
        check8("R1 reset ready", {7'd0, ready}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // program success
        cyc(C_PROG, 3, 1, 1, 1);
        check8("R3 busy after program", status, 8'h00);
        cyc(C_NONE, 0, 1, 1, 1);
        cyc(C_NONE, 0, 1, 1, 1);
        check8("R12 program passes", status, 8'h80);

        // program failure, then stray resume
        cyc(C_PROG, 5, 1, 1, 0);
        cyc(C_NONE, 0, 1, 1, 0);
        cyc(C_NONE, 0, 1, 1, 0);
        check8("R6 program fail", status, 8'h90);
        cyc(C_RES, 0, 1, 1, 1);
        check8("R9 resume ignored", status, 8'h90);
        cyc(C_CLR, 0, 1, 1, 1);
        check8("R10 clear", status, 8'h80);

        // locking
        cyc(C_ERASE, NB - 1, 0, 1, 1);
        check8("R4 top block locked", status, 8'h82);
        cyc(C_CLR, 0, 1, 1, 1);
        cyc(C_PROG, NB - 2, 0, 1, 1);
        check8("R4 second block locked", status, 8'h82);
        cyc(C_CLR, 0, 1, 1, 1);
        cyc(C_PROG, NB - 3, 0, 1, 1);
        check8("R4 lower block open", status, 8'h00);
        cyc(C_NONE, 0, 1, 1, 1);
        cyc(C_NONE, 0, 1, 1, 1);
        cyc(C_ERASE, NB - 1, 1, 1, 1);
        check8("R4 unprotected accepted", status, 8'h00);
        cyc(C_NONE, 0, 1, 1, 1);
        cyc(C_NONE, 0, 1, 1, 1);
        check8("R12 erase passes", status, 8'h80);

        // supply low at issue and at verify
        cyc(C_ERASE, 2, 1, 0, 1);
        check8("R5 supply low at issue", status, 8'h88);
        cyc(C_CLR, 0, 1, 1, 1);
        cyc(C_PROG, 2, 1, 1, 1);
        cyc(C_NONE, 0, 1, 0, 1);
        check8("R5 supply ignored during pulse", status, 8'h00);
        cyc(C_NONE, 0, 1, 0, 1);
        check8("R5 supply low at verify", status, 8'h88);
        cyc(C_CLR, 0, 1, 1, 1);

        // erase exhausting the pulse limit
        begin
            int busy = 1;
            cyc(C_ERASE, 7, 1, 1, 0);
            for (int i = 0; i < 4 * PL && !ready; i++) begin
                cyc(C_NONE, 0, 1, 1, 0);
                if (!ready) busy++;
            end
            check8("R7 erase busy cycles", 8'(busy), 8'(2 * PL));
            check8("R7 erase fail", status, 8'hA0);
        end
        cyc(C_CLR, 0, 1, 1, 1);

        // erase suspend / resume
        cyc(C_ERASE, 4, 1, 1, 0);
        cyc(C_SUSP, 0, 1, 1, 0);
        check8("R8 erase suspended", status, 8'hC0);
        cyc(C_NONE, 0, 1, 1, 0);
        cyc(C_NONE, 0, 1, 1, 0);
        check8("R8 suspend holds", status, 8'hC0);
        cyc(C_CLR, 0, 1, 1, 1);
        check8("R10 clear keeps suspend", status, 8'hC0);
        cyc(C_RES, 0, 1, 1, 1);
        check8("R8 resumed busy", status, 8'h00);
        cyc(C_NONE, 0, 1, 1, 1);
        cyc(C_NONE, 0, 1, 1, 1);
        check8("R12 resumed erase done", status, 8'h80);

        // program suspend at verify phase
        cyc(C_PROG, 1, 1, 1, 1);
        cyc(C_NONE, 0, 1, 1, 1);
        cyc(C_SUSP, 0, 1, 1, 1);
        check8("R8 program suspended", status, 8'h84);
        cyc(C_RES, 0, 1, 1, 1);
        check8("R8 program resumed", status, 8'h00);
        cyc(C_NONE, 0, 1, 1, 1);
        cyc(C_NONE, 0, 1, 1, 1);
        check8("R12 resumed program done", status, 8'h80);

        // sequence error
        cyc(C_SEQ, 0, 1, 1, 1);
        check8("R11 sequence error", status, 8'hB0);
        cyc(C_CLR, 0, 1, 1, 1);
        check8("R10 clear after seqerr", status, 8'h80);

        // random run against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [2:0] op;
            r = $urandom_range(0, 11);
            case (r)
                0, 1, 2, 3: op = C_NONE;
                4: op = C_PROG;
                5: op = C_ERASE;
                6: op = C_SUSP;
                7: op = C_RES;
                8: op = C_CLR;
                9: op = C_SEQ;
                10: op = 3'd7;
                default: op = C_PROG;
            endcase
            cyc(op, $urandom_range(0, NB - 1), $urandom_range(0, 3) != 0,
                $urandom_range(0, 7) != 0, $urandom_range(0, 1) != 0);
            check8("R3-model status", status, model_status());
            check8("R2 ready mirrors bit7 and bit0 zero", {6'd0, ready, status[0]}, {6'd0, status[7], 1'b0});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule